// File: doc/BRIEF.md
# Two-Port Shared Parity SRAM Controller

This block fronts a single-port SRAM that one subsystem's CPU and its DMA engine share. Each master drives its own request port, and the two ports use a valid/ready handshake. A round-robin arbiter lets at most one access into the array per clock. Each port carries the identity of the master that drives it. The controller turns away any identity other than the one that belongs to that port. It also applies per-master write and fetch rights that come from plain configuration pins. The memory has no security gating: any legal master may read its data.

Every stored word keeps one even-parity bit per byte. The parity of byte 0 also folds in the word address, so a word that comes back from the wrong row fails the check. When a read fails, the controller raises a one-cycle parity-error pulse. It also sets a sticky flag and captures the address, and both hold until software clears them. A refused access is reported on a violation pulse, which names the port and the identity that was offered. A test input can flip stored parity bits on a write, so the error path can be exercised.

Back-pressure rules: a master raises `*_valid` and holds `valid` and every request field stable until it samples `*_ready` high at a clock edge. That edge is the transfer. A losing requester simply stays asserted. Responses cannot be stalled. `*_rvalid` is a one-cycle pulse, and the master must take the data in that cycle.

Top module: `spa_shared_ram`

## Requirements
- R1: `cpu_ready`/`dma_ready` are high only for a port whose valid is high, at most one of them is high in a cycle, and a port requesting alone is granted in the same cycle.
- R2: When both ports request in the same cycle, the port not granted most recently wins. After reset the CPU port (port 0) wins the first tie.
- R3: Port 0 accepts only identity `CPU_ID` (default 1) and port 1 only `DMA_ID` (default 2). Any other identity is refused.
- R4: A write needs `cfg_wr_allow[p]`, and a fetch (`we`=0, `fetch`=1) needs `cfg_fx_allow[p]`, where bit 0 is the CPU port and bit 1 the DMA port. A data read (`we`=0, `fetch`=0) from a legal identity is always allowed, and `we`=1 means a write whatever `fetch` is.
- R5: An accepted read or fetch gives a one-cycle `rvalid` on its own port in the cycle after the transfer, with the stored word on `rdata`. Writes give no response.
- R6: A refused access writes nothing. A refused read or fetch still returns `rvalid`, with `rdata` zero. `viol_pulse` rises in the cycle after the transfer, with `viol_port` (0 = CPU, 1 = DMA) and `viol_id` giving the offending request.
- R7: Each written word stores 4 parity bits, where bit b is the XOR of data byte b. Bit 0 also XORs in every address bit. `inj_par_flip` is XORed into the stored bits on a write.
- R8: `perr_pulse` is high in the `rvalid` cycle of a legal read whose recomputed parity differs from the stored bits. It is never high for a refused access.
- R9: The cycle after a parity error, `perr_flag` is set and `perr_addr` holds the failing address. `perr_clr` clears the flag, and a new error in the same cycle as `perr_clr` takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU port request valid |
| cpu_ready | output | 1 | CPU port request accepted this cycle |
| cpu_id | input | ID_W | Identity of the master on the CPU port |
| cpu_we | input | 1 | CPU port write |
| cpu_fetch | input | 1 | CPU port instruction fetch (when not writing) |
| cpu_addr | input | ADDR_W | CPU port word address |
| cpu_wdata | input | DATA_W | CPU port write data |
| cpu_rvalid | output | 1 | CPU port read response pulse |
| cpu_rdata | output | DATA_W | CPU port read data |
| dma_valid | input | 1 | DMA port request valid |
| dma_ready | output | 1 | DMA port request accepted this cycle |
| dma_id | input | ID_W | Identity of the master on the DMA port |
| dma_we | input | 1 | DMA port write |
| dma_fetch | input | 1 | DMA port fetch (when not writing) |
| dma_addr | input | ADDR_W | DMA port word address |
| dma_wdata | input | DATA_W | DMA port write data |
| dma_rvalid | output | 1 | DMA port read response pulse |
| dma_rdata | output | DATA_W | DMA port read data |
| cfg_wr_allow | input | 2 | Per-port write permission |
| cfg_fx_allow | input | 2 | Per-port fetch permission |
| inj_par_flip | input | DATA_W/8 | Parity bits flipped on writes (test) |
| perr_clr | input | 1 | Clears the sticky parity-error flag |
| viol_pulse | output | 1 | Access refused (one cycle) |
| viol_port | output | 1 | Port of the refused access |
| viol_id | output | ID_W | Identity of the refused access |
| perr_pulse | output | 1 | Parity error on this read response |
| perr_flag | output | 1 | Sticky parity-error flag |
| perr_addr | output | ADDR_W | Address of the latest parity error |

## Verification
The bench goes after fairness on back-to-back ties. An arbiter that kept a fixed priority would starve the DMA port, and that shows up as a mismatch on `dma_ready`.

It sends foreign identities, forbidden writes and forbidden fetches. A design that leaked any of these would return real data instead of zero, or would change a word that a later read checks.

Parity errors are raised with injected flips, including an error that arrives in the same cycle as `perr_clr`. A design whose clear beat the new error would drop the flag. One that checked refused reads would pulse `perr_pulse` falsely.

// File: rtl/spa_pkg.sv
`timescale 1ns/1ps
package spa_pkg;
  localparam int NPORT = 2;

  typedef enum logic {
    PORT_CPU = 1'b0,
    PORT_DMA = 1'b1
  } port_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e acc_kind(input logic we, input logic fetch);
    if (we)         return ACC_WRITE;
    else if (fetch) return ACC_FETCH;
    else            return ACC_READ;
  endfunction
endpackage

// File: rtl/spa_rr_arb.sv
`timescale 1ns/1ps
module spa_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d;

  // Scan from the pointer; first requester wins, pointer moves past it.
  always_comb begin
    gnt   = '0;
    ptr_d = ptr_q;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (gnt == '0 && req[idx]) begin
        gnt[idx] = 1'b1;
        if (idx == N - 1) ptr_d = '0;
        else              ptr_d = PW'(idx + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r1_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r2_tie_to_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (&req) |-> gnt[ptr_q]);
endmodule

// File: rtl/spa_access_gate.sv
`timescale 1ns/1ps
module spa_access_gate
  import spa_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int CPU_ID = 1,
  parameter int DMA_ID = 2
) (
  input  logic            port_sel,
  input  logic [ID_W-1:0] id,
  input  logic            we,
  input  logic            fetch,
  input  logic [NPORT-1:0] wr_allow,
  input  logic [NPORT-1:0] fx_allow,
  output logic            allow
);
  localparam logic [ID_W-1:0] CPU_IDV = ID_W'(CPU_ID);
  localparam logic [ID_W-1:0] DMA_IDV = ID_W'(DMA_ID);

  logic id_ok;
  logic right_ok;

  always_comb begin
    id_ok = (port_sel == PORT_DMA) ? (id == DMA_IDV) : (id == CPU_IDV);
    unique case (acc_kind(we, fetch))
      ACC_WRITE: right_ok = wr_allow[port_sel];
      ACC_FETCH: right_ok = fx_allow[port_sel];
      default:   right_ok = 1'b1;
    endcase
    allow = id_ok & right_ok;
  end
endmodule

// File: rtl/spa_par_ram.sv
`timescale 1ns/1ps
module spa_par_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] par_flip,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              mismatch
);
  localparam int NB    = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [NB-1:0]     mem_p [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [NB-1:0]     rp_q;
  logic [ADDR_W-1:0] ra_q;

  function automatic logic [NB-1:0] par_calc(input logic [DATA_W-1:0] d,
                                             input logic [ADDR_W-1:0] a);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[b*8 +: 8];
    p[0] = p[0] ^ (^a);
    return p;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_d[addr] <= wdata;
      mem_p[addr] <= par_calc(wdata, addr) ^ par_flip;
    end
    if (rd_en) begin
      rd_q <= mem_d[addr];
      rp_q <= mem_p[addr];
      ra_q <= addr;
    end
  end

  assign rdata    = rd_q;
  assign raddr    = ra_q;
  assign mismatch = (par_calc(rd_q, ra_q) != rp_q);
endmodule

// File: rtl/spa_shared_ram.sv
`timescale 1ns/1ps
module spa_shared_ram
  import spa_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int CPU_ID = 1,
  parameter int DMA_ID = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic [ID_W-1:0]     cpu_id,
  input  logic                cpu_we,
  input  logic                cpu_fetch,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_rvalid,
  output logic [DATA_W-1:0]   cpu_rdata,
  input  logic                dma_valid,
  output logic                dma_ready,
  input  logic [ID_W-1:0]     dma_id,
  input  logic                dma_we,
  input  logic                dma_fetch,
  input  logic [ADDR_W-1:0]   dma_addr,
  input  logic [DATA_W-1:0]   dma_wdata,
  output logic                dma_rvalid,
  output logic [DATA_W-1:0]   dma_rdata,
  input  logic [1:0]          cfg_wr_allow,
  input  logic [1:0]          cfg_fx_allow,
  input  logic [DATA_W/8-1:0] inj_par_flip,
  input  logic                perr_clr,
  output logic                viol_pulse,
  output logic                viol_port,
  output logic [ID_W-1:0]     viol_id,
  output logic                perr_pulse,
  output logic                perr_flag,
  output logic [ADDR_W-1:0]   perr_addr
);
  logic [NPORT-1:0] req_v, gnt;
  logic             sel, any_g, allow;
  logic [ID_W-1:0]  s_id;
  logic             s_we, s_fetch;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic             mem_we, mem_re;
  logic [DATA_W-1:0] ram_rdata;
  logic [ADDR_W-1:0] ram_raddr;
  logic             ram_mm;
  logic [NPORT-1:0] rsp_v_q;
  logic             viol_q, viol_port_q;
  logic [ID_W-1:0]  viol_id_q;
  logic             flag_q;
  logic [ADDR_W-1:0] paddr_q;

  assign req_v = {dma_valid, cpu_valid};

  spa_rr_arb #(.N(NPORT)) u_arb (
    .clk (clk),
    .rst_n(rst_n),
    .req (req_v),
    .gnt (gnt)
  );

  assign cpu_ready = gnt[PORT_CPU];
  assign dma_ready = gnt[PORT_DMA];
  assign sel       = gnt[PORT_DMA];
  assign any_g     = |gnt;

  always_comb begin
    s_id    = sel ? dma_id    : cpu_id;
    s_we    = sel ? dma_we    : cpu_we;
    s_fetch = sel ? dma_fetch : cpu_fetch;
    s_addr  = sel ? dma_addr  : cpu_addr;
    s_wdata = sel ? dma_wdata : cpu_wdata;
  end

  spa_access_gate #(.ID_W(ID_W), .CPU_ID(CPU_ID), .DMA_ID(DMA_ID)) u_gate (
    .port_sel(sel),
    .id      (s_id),
    .we      (s_we),
    .fetch   (s_fetch),
    .wr_allow(cfg_wr_allow),
    .fx_allow(cfg_fx_allow),
    .allow   (allow)
  );

  assign mem_we = any_g & allow & s_we;
  assign mem_re = any_g & allow & ~s_we;

  spa_par_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .wr_en   (mem_we),
    .rd_en   (mem_re),
    .addr    (s_addr),
    .wdata   (s_wdata),
    .par_flip(inj_par_flip),
    .rdata   (ram_rdata),
    .raddr   (ram_raddr),
    .mismatch(ram_mm)
  );

  // Response and violation stage: one register after the transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q     <= '0;
      viol_q      <= 1'b0;
      viol_port_q <= 1'b0;
      viol_id_q   <= '0;
    end else begin
      rsp_v_q <= gnt & {NPORT{~s_we}};
      viol_q  <= any_g & ~allow;
      if (any_g && !allow) begin
        viol_port_q <= sel;
        viol_id_q   <= s_id;
      end
    end
  end

  assign cpu_rvalid = rsp_v_q[PORT_CPU];
  assign dma_rvalid = rsp_v_q[PORT_DMA];
  assign cpu_rdata  = (rsp_v_q[PORT_CPU] && !viol_q) ? ram_rdata : '0;
  assign dma_rdata  = (rsp_v_q[PORT_DMA] && !viol_q) ? ram_rdata : '0;
  assign viol_pulse = viol_q;
  assign viol_port  = viol_port_q;
  assign viol_id    = viol_id_q;
  assign perr_pulse = (|rsp_v_q) & ~viol_q & ram_mm;

  // Sticky error: a fresh error outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      paddr_q <= '0;
    end else if (perr_pulse) begin
      flag_q  <= 1'b1;
      paddr_q <= ram_raddr;
    end else if (perr_clr) begin
      flag_q  <= 1'b0;
    end
  end

  assign perr_flag = flag_q;
  assign perr_addr = paddr_q;

  a_r5_cpu_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_valid && cpu_ready && !cpu_we));
  a_r5_dma_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rvalid |-> $past(dma_valid && dma_ready && !dma_we));
  a_r6_no_write_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> !$past(mem_we));
  a_r9_flag_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    perr_pulse |=> perr_flag);
  a_r9_addr_captured: assert property (@(posedge clk) disable iff (!rst_n)
    perr_pulse |=> (perr_addr == $past(ram_raddr)));
endmodule

// File: tb/tb_spa_shared_ram.sv
`timescale 1ns/1ps
module tb_spa_shared_ram;
  localparam int AW = 6, DW = 32, IW = 3, CID = 1, DID = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic c_v, c_we, c_fx, d_v, d_we, d_fx;
  logic [IW-1:0] c_id, d_id;
  logic [AW-1:0] c_addr, d_addr;
  logic [DW-1:0] c_wd, d_wd;
  logic [1:0] cfg_wr, cfg_fx;
  logic [3:0] inj;
  logic clr;

  logic cpu_ready, dma_ready, cpu_rvalid, dma_rvalid;
  logic [DW-1:0] cpu_rdata, dma_rdata;
  logic viol_pulse, viol_port, perr_pulse, perr_flag;
  logic [IW-1:0] viol_id;
  logic [AW-1:0] perr_addr;

  spa_shared_ram #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .CPU_ID(CID), .DMA_ID(DID)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(c_v), .cpu_ready(cpu_ready), .cpu_id(c_id), .cpu_we(c_we),
    .cpu_fetch(c_fx), .cpu_addr(c_addr), .cpu_wdata(c_wd),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .dma_valid(d_v), .dma_ready(dma_ready), .dma_id(d_id), .dma_we(d_we),
    .dma_fetch(d_fx), .dma_addr(d_addr), .dma_wdata(d_wd),
    .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
    .cfg_wr_allow(cfg_wr), .cfg_fx_allow(cfg_fx), .inj_par_flip(inj),
    .perr_clr(clr), .viol_pulse(viol_pulse), .viol_port(viol_port),
    .viol_id(viol_id), .perr_pulse(perr_pulse), .perr_flag(perr_flag),
    .perr_addr(perr_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_data [DEPTH];
  logic [3:0]    m_par  [DEPTH];
  bit last_dma;
  bit m_flag;
  logic [AW-1:0] m_paddr;
  bit g_c, g_d;
  // expectations for the current cycle (e_) and the next one (n_)
  bit [1:0] e_rv, n_rv;
  logic [DW-1:0] e_rd, n_rd;
  bit e_viol, n_viol, e_vport, n_vport, e_perr, n_perr;
  logic [IW-1:0] e_vid, n_vid;
  logic [AW-1:0] e_paddr, n_paddr;

  function automatic logic [3:0] calc_par(input logic [DW-1:0] d, input logic [AW-1:0] a);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^d[b*8 +: 8];
    p[0] = p[0] ^ (^a);
    return p;
  endfunction

  function automatic logic [DW-1:0] init_val(input int a);
    return (32'h01010101 * a) ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic serve(input bit p, input logic [IW-1:0] id, input logic we,
                       input logic fx, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    bit legal;
    legal = (id == (p ? IW'(DID) : IW'(CID))) &&
            (we ? cfg_wr[p] : (fx ? cfg_fx[p] : 1'b1));
    if (!legal) begin
      n_viol = 1'b1; n_vport = p; n_vid = id;
      if (!we) begin n_rv[p] = 1'b1; n_rd = '0; end
    end else if (we) begin
      m_data[a] = wd;
      m_par[a]  = calc_par(wd, a) ^ inj;
    end else begin
      n_rv[p] = 1'b1;
      n_rd    = m_data[a];
      n_perr  = (calc_par(m_data[a], a) != m_par[a]);
      n_paddr = a;
    end
  endtask

  // Called just after a falling edge with the inputs set for this cycle.
  task automatic step();
    #1;
    chk("R5 cpu_rvalid", cpu_rvalid, e_rv[0]);
    chk("R5 dma_rvalid", dma_rvalid, e_rv[1]);
    if (e_rv[0]) chk(e_viol ? "R6 cpu_rdata" : "R5 cpu_rdata", cpu_rdata, e_rd);
    if (e_rv[1]) chk(e_viol ? "R6 dma_rdata" : "R5 dma_rdata", dma_rdata, e_rd);
    chk("R6 viol_pulse", viol_pulse, e_viol);
    if (e_viol) begin
      chk("R6 viol_port", viol_port, e_vport);
      chk("R6 viol_id", viol_id, e_vid);
    end
    chk("R8 perr_pulse", perr_pulse, e_perr);
    chk("R9 perr_flag", perr_flag, m_flag);
    chk("R9 perr_addr", perr_addr, m_paddr);
    g_c = c_v && (!d_v || last_dma);
    g_d = d_v && !g_c;
    chk((c_v && d_v) ? "R2 cpu_ready" : "R1 cpu_ready", cpu_ready, g_c);
    chk((c_v && d_v) ? "R2 dma_ready" : "R1 dma_ready", dma_ready, g_d);
    if (e_perr) begin m_flag = 1'b1; m_paddr = e_paddr; end
    else if (clr) m_flag = 1'b0;
    n_rv = '0; n_rd = '0; n_viol = 1'b0; n_vport = 1'b0; n_vid = '0;
    n_perr = 1'b0; n_paddr = '0;
    if (g_c) begin serve(1'b0, c_id, c_we, c_fx, c_addr, c_wd); last_dma = 1'b0; end
    if (g_d) begin serve(1'b1, d_id, d_we, d_fx, d_addr, d_wd); last_dma = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    e_rv = n_rv; e_rd = n_rd; e_viol = n_viol; e_vport = n_vport; e_vid = n_vid;
    e_perr = n_perr; e_paddr = n_paddr;
  endtask

  task automatic cpu_req(input logic [IW-1:0] id, input logic we, input logic fx,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd);
    c_v = 1'b1; c_id = id; c_we = we; c_fx = fx; c_addr = a; c_wd = wd;
  endtask

  task automatic dma_req(input logic [IW-1:0] id, input logic we, input logic fx,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd);
    d_v = 1'b1; d_id = id; d_we = we; d_fx = fx; d_addr = a; d_wd = wd;
  endtask

  task automatic one_cpu(input logic [IW-1:0] id, input logic we, input logic fx,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd);
    cpu_req(id, we, fx, a, wd); step(); c_v = 1'b0;
  endtask

  task automatic one_dma(input logic [IW-1:0] id, input logic we, input logic fx,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd);
    dma_req(id, we, fx, a, wd); step(); d_v = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    c_v = 0; c_we = 0; c_fx = 0; c_id = '0; c_addr = '0; c_wd = '0;
    d_v = 0; d_we = 0; d_fx = 0; d_id = '0; d_addr = '0; d_wd = '0;
    cfg_wr = 2'b11; cfg_fx = 2'b11; inj = '0; clr = 1'b0;
    last_dma = 1'b1; m_flag = 1'b0; m_paddr = '0;
    e_rv = '0; e_rd = '0; e_viol = 0; e_vport = 0; e_vid = '0; e_perr = 0; e_paddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset state
    chk("R1 reset cpu_ready", cpu_ready, 0);
    chk("R1 reset dma_ready", dma_ready, 0);
    chk("R5 reset rvalid", {cpu_rvalid, dma_rvalid}, 0);
    chk("R6 reset viol", viol_pulse, 0);
    chk("R9 reset flag", perr_flag, 0);
    chk("R9 reset addr", perr_addr, 0);
    @(negedge clk);

    // Fill the array
    for (int a = 0; a < DEPTH; a++) one_cpu(IW'(CID), 1'b1, 1'b0, AW'(a), init_val(a));

    // Ties: first tie after a CPU grant goes to DMA, then CPU again
    cpu_req(IW'(CID), 0, 0, 6'd3, '0); dma_req(IW'(DID), 0, 0, 6'd5, '0);
    step(); chk("R2 tie after cpu grant", {g_c, g_d}, 2'b01);
    d_v = 0; cpu_req(IW'(CID), 0, 0, 6'd3, '0); dma_req(IW'(DID), 0, 0, 6'd6, '0);
    step(); chk("R2 tie after dma grant", {g_c, g_d}, 2'b10);
    c_v = 0; step(); d_v = 0; step();

    // Wrong identity on each port
    one_cpu(3'd5, 0, 0, 6'd4, '0);
    chk("R3 foreign id viol_id", viol_id, 5);
    chk("R3 foreign id rdata", cpu_rdata, 0);
    one_dma(IW'(CID), 1, 0, 6'd8, 32'hFFFF_0000);
    chk("R3 cpu id on dma port", {viol_pulse, viol_port}, 2'b11);
    one_dma(IW'(DID), 0, 0, 6'd8, '0);
    chk("R3 no write from foreign id", dma_rdata, init_val(8));

    // Write permission
    cfg_wr = 2'b01;
    one_dma(IW'(DID), 1, 0, 6'd7, 32'hDEAD_BEEF);
    one_dma(IW'(DID), 0, 0, 6'd7, '0);
    chk("R4 denied write left word", dma_rdata, init_val(7));
    one_cpu(IW'(CID), 1, 0, 6'd7, 32'h1357_2468);
    one_cpu(IW'(CID), 0, 0, 6'd7, '0);
    chk("R4 allowed write", cpu_rdata, 32'h1357_2468);
    cfg_wr = 2'b11;

    // Fetch permission; data reads unaffected
    cfg_fx = 2'b10;
    one_cpu(IW'(CID), 0, 1, 6'd2, '0);
    chk("R4 fetch denied", {viol_pulse, cpu_rdata}, {1'b1, 32'h0});
    one_cpu(IW'(CID), 0, 0, 6'd2, '0);
    chk("R4 data read allowed", cpu_rdata, init_val(2));
    one_dma(IW'(DID), 0, 1, 6'd2, '0);
    chk("R4 dma fetch allowed", dma_rdata, init_val(2));
    cfg_fx = 2'b11;

    // Parity injection, clear, and error versus clear
    inj = 4'b0100; one_cpu(IW'(CID), 1, 0, 6'd9, 32'hCAFE_F00D); inj = '0;
    one_cpu(IW'(CID), 0, 0, 6'd9, '0);
    chk("R7 injected flip detected", perr_pulse, 1);
    step();
    chk("R9 flag set", perr_flag, 1);
    chk("R9 addr held", perr_addr, 9);
    clr = 1'b1; step(); clr = 1'b0;
    chk("R9 flag cleared", perr_flag, 0);
    one_cpu(IW'(CID), 1, 0, 6'd9, 32'hCAFE_F00D);
    one_cpu(IW'(CID), 0, 0, 6'd9, '0);
    chk("R7 clean word no error", perr_pulse, 0);
    inj = 4'b0001; one_dma(IW'(DID), 1, 0, 6'd10, 32'h0F0F_0F0F); inj = '0;
    one_dma(IW'(DID), 0, 0, 6'd10, '0);
    clr = 1'b1; step(); clr = 1'b0;
    chk("R9 error beats clear", {perr_flag, perr_addr}, {1'b1, 6'd10});

    // Random mix with held requests
    for (int i = 0; i < 4000; i++) begin
      if (!c_v && ($urandom % 3 == 0))
        cpu_req(($urandom % 10 == 0) ? IW'($urandom) : IW'(CID), ($urandom % 3 == 0),
                ($urandom % 2 == 0), AW'($urandom), $urandom);
      if (!d_v && ($urandom % 3 == 0))
        dma_req(($urandom % 10 == 0) ? IW'($urandom) : IW'(DID), ($urandom % 3 == 0),
                ($urandom % 2 == 0), AW'($urandom), $urandom);
      if ($urandom % 50 == 0) begin cfg_wr = 2'($urandom); cfg_fx = 2'($urandom); end
      inj = ($urandom % 16 == 0) ? 4'($urandom) : 4'h0;
      clr = ($urandom % 20 == 0);
      step();
      if (g_c) c_v = 1'b0;
      if (g_d) d_v = 1'b0;
    end
    c_v = 0; d_v = 0; clr = 0; inj = '0;
    step(); step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule